// File: doc/BRIEF.md
# Streaming Prewitt Edge Detector

This block takes a grayscale image as a raster-ordered pixel stream, one pixel per accepted clock, and turns it into an edge stream. Two line memories hold the two lines above the incoming one. A sliding 3 × 3 window is built from those two memories and the live pixel. Two gradient paths of identical structure read that window in parallel: one takes right column minus left column, the other takes bottom row minus top row. Neither path uses a multiplier. The sum of the two magnitudes is either saturated to 8 bits and sent out as a gradient image, or compared with a threshold and sent out as a binary edge map.

A frame begins with a start-of-frame flag on its first pixel. Results come out in raster order with a lag of one line plus one pixel, so the host drains a frame by sending one line plus one more filler pixel after the last real pixel. The filler values count as zero. Window positions outside the image are zero on all four sides. A two-entry configuration port sets the threshold and the output mode. The default geometry is 640 × 480 with 8-bit pixels, and all of it is set by parameters.

Top module: `prewitt_edge_stream`

## Requirements
- R1: While reset is held and on the first cycle after it, `outValid` is 0 and `outPix` is 0. The mode resets to gradient and the threshold resets to 0.
- R2: A frame that is fully drained gives exactly IMG_H × IMG_W results, in raster order of their centre pixel. The first result comes no earlier than the accepted pixel at frame index IMG_W + 1, which means one complete line plus one pixel must arrive before any output.
- R3: In gradient mode the result for centre (r, c) is min(255, |Gx| + |Gy|). Gx is the sum of the right column of the 3 × 3 window minus the sum of its left column. Gy is the sum of the bottom row minus the sum of the top row.
- R4: In binary mode the result is 255 when |Gx| + |Gy| is strictly greater than the threshold, and 0 otherwise. This includes the case where the sum equals the threshold, which gives 0.
- R5: Window pixels outside the image are taken as zero. This covers the row above the frame, the row below it, the column left of column 0 and the column right of column IMG_W−1. Filler pixels sent after the last image pixel are zero whatever value they carry.
- R6: A gradient sum above 255 is clamped to 255. It never wraps.
- R7: The result for centre raster index k appears on the port two clocks after the clock edge that accepts the pixel with frame index k + IMG_W + 1. `outValid` is never high unless a pixel was accepted three sampling edges earlier.
- R8: Idle cycles with `pixValid` low may fall anywhere in the stream. They delay results but do not change their values or their order.
- R9: A pixel with `sof` high starts a new frame, even in the middle of another frame. Pixels from the earlier frame have no effect on the new frame's results.
- R10: The block ignores pixels that arrive before the first `sof`, and pixels that arrive after frame index IMG_H × IMG_W + IMG_W. Such pixels produce no output.
- R11: A write with `cfgSel` = 0 loads the full `cfgData` byte as the threshold and leaves the mode unchanged. A write with `cfgSel` = 1 loads the mode from `cfgData` bit 0, where 0 selects gradient and 1 selects binary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sof | input | 1 | Marks the accepted pixel as the first pixel of a frame |
| pixValid | input | 1 | Pixel strobe; the block accepts a pixel on each clock where this is high |
| pixIn | input | PIX_W | Grayscale pixel value |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 1 | Configuration target: 0 selects the threshold, 1 selects the mode |
| cfgData | input | PIX_W | Configuration write data |
| outValid | output | 1 | High for one cycle for each result |
| outPix | output | PIX_W | Gradient magnitude, or 0/255 edge flag in binary mode |

## Verification
The bench works on a small frame and checks the border ring against a model that treats positions outside the image as zero. A design that wrapped around columns, or let old line-memory contents leak into the top row, would get the edge values wrong. Images with all pixels at full scale drive the corner sums above 255, which exposes a clamp that wraps. A flat image whose edge sums equal the threshold exposes a greater-or-equal comparison. Random idle gaps, a frame abandoned part-way through, filler pixels with non-zero values and stray pixels before `sof` or after the drain would show up as extra, missing, shifted or mistimed results.

// File: rtl/edge_pkg.sv
package edge_pkg;

  // Per-pixel strobes passed from the control module to the datapath.
  typedef struct packed {
    logic accept;     // a pixel is taken this cycle
    logic topZero;    // captured column: row above the window is outside the frame
    logic botZero;    // captured column: bottom row is beyond the frame or is filler
    logic emit;       // the window completed by this pixel is a real result
    logic leftZero;   // window centre sits in column 0
    logic rightZero;  // window centre sits in the last column
  } edgeStrobe_t;

  typedef enum logic {
    MODE_GRAD = 1'b0,
    MODE_BIN  = 1'b1
  } outMode_t;

endpackage

// File: rtl/edge_axis_grad.sv
// One gradient axis: |sum(plus) - sum(minus)| over three window pixels each.
module edge_axis_grad #(
  parameter int PIX_W = 8,
  parameter int SUM_W = PIX_W + 2
) (
  input  logic [3*PIX_W-1:0] plusPix,
  input  logic [3*PIX_W-1:0] minusPix,
  output logic [SUM_W-1:0]   mag
);

  logic [SUM_W-1:0] plusSum;
  logic [SUM_W-1:0] minusSum;

  always_comb begin
    plusSum  = '0;
    minusSum = '0;
    for (int i = 0; i < 3; i++) begin
      plusSum  = plusSum  + SUM_W'(plusPix[i*PIX_W +: PIX_W]);
      minusSum = minusSum + SUM_W'(minusPix[i*PIX_W +: PIX_W]);
    end
    if (plusSum >= minusSum) mag = plusSum - minusSum;
    else                     mag = minusSum - plusSum;
  end

endmodule

// File: rtl/edge_ctrl.sv
// Frame position tracking, border/validity strobes and configuration registers.
module edge_ctrl
  import edge_pkg::*;
#(
  parameter int IMG_W = 640,
  parameter int IMG_H = 480,
  parameter int PIX_W = 8,
  localparam int COL_W = $clog2(IMG_W),
  localparam int ROW_W = $clog2(IMG_H + 2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sof,
  input  logic             pixValid,
  input  logic             cfgWe,
  input  logic             cfgSel,
  input  logic [PIX_W-1:0] cfgData,
  output edgeStrobe_t      strobe,
  output logic [COL_W-1:0] lbAddr,
  output logic [PIX_W-1:0] threshold,
  output outMode_t         mode
);

  logic             active;
  logic [COL_W-1:0] colCnt;
  logic [ROW_W-1:0] rowCnt;

  logic             frameStart;
  logic             take;
  logic [COL_W-1:0] curCol;
  logic [ROW_W-1:0] curRow;
  logic             lastCol;
  logic             finalPix;

  always_comb begin
    frameStart = pixValid && sof;
    take       = pixValid && (frameStart || active);
    curCol     = frameStart ? '0 : colCnt;
    curRow     = frameStart ? '0 : rowCnt;
    lastCol    = (curCol == COL_W'(IMG_W - 1));
    finalPix   = (curRow == ROW_W'(IMG_H + 1)) && (curCol == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
      colCnt <= '0;
      rowCnt <= '0;
    end else if (take) begin
      active <= !finalPix;
      colCnt <= lastCol ? '0 : curCol + COL_W'(1);
      rowCnt <= lastCol ? curRow + ROW_W'(1) : curRow;
    end
  end

  always_comb begin
    strobe.accept    = take;
    strobe.topZero   = curRow < ROW_W'(2);
    strobe.botZero   = curRow >= ROW_W'(IMG_H);
    strobe.emit      = take && ((curRow >= ROW_W'(2)) ||
                                ((curRow == ROW_W'(1)) && (curCol != '0)));
    strobe.leftZero  = (curCol == COL_W'(1));
    strobe.rightZero = (curCol == '0);
    lbAddr           = curCol;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      threshold <= '0;
      mode      <= MODE_GRAD;
    end else if (cfgWe) begin
      if (cfgSel) mode      <= outMode_t'(cfgData[0]);
      else        threshold <= cfgData;
    end
  end

endmodule

// File: rtl/edge_datapath.sv
// Line memories, 3x3 window, two gradient axes, combine / clamp / threshold.
module edge_datapath
  import edge_pkg::*;
#(
  parameter int IMG_W = 640,
  parameter int PIX_W = 8,
  localparam int COL_W  = $clog2(IMG_W),
  localparam int NUM_LB = 2,
  localparam int SUM_W  = PIX_W + 2,
  localparam int MAG_W  = SUM_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PIX_W-1:0] pixIn,
  input  edgeStrobe_t      strobe,
  input  logic [COL_W-1:0] lbAddr,
  input  logic [PIX_W-1:0] threshold,
  input  outMode_t         mode,
  output logic             outValid,
  output logic [PIX_W-1:0] outPix
);

  // tap[0] is the live (bottom) pixel, tap[g+1] the same column g+1 lines up.
  logic [PIX_W-1:0] tap [NUM_LB+1];
  assign tap[0] = strobe.botZero ? '0 : pixIn;

  for (genvar g = 0; g < NUM_LB; g++) begin : g_line
    logic [PIX_W-1:0] lineMem [IMG_W];
    assign tap[g+1] = lineMem[lbAddr];
    always_ff @(posedge clk) begin
      if (strobe.accept) lineMem[lbAddr] <= tap[g];
    end
  end

  // Window: win[column][row], column 0 = left, row 0 = top.
  logic [PIX_W-1:0] win [3][3];
  logic             s1Emit, s1ZeroL, s1ZeroR;

  always_ff @(posedge clk) begin
    if (strobe.accept) begin
      win[2][0] <= strobe.topZero ? '0 : tap[NUM_LB];
      win[2][1] <= tap[1];
      win[2][2] <= tap[0];
      win[1]    <= win[2];
      win[0]    <= win[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Emit  <= 1'b0;
      s1ZeroL <= 1'b0;
      s1ZeroR <= 1'b0;
    end else begin
      s1Emit  <= strobe.emit;
      s1ZeroL <= strobe.leftZero;
      s1ZeroR <= strobe.rightZero;
    end
  end

  logic [PIX_W-1:0] lPix [3];
  logic [PIX_W-1:0] cPix [3];
  logic [PIX_W-1:0] rPix [3];

  always_comb begin
    for (int i = 0; i < 3; i++) begin
      lPix[i] = s1ZeroL ? '0 : win[0][i];
      cPix[i] = win[1][i];
      rPix[i] = s1ZeroR ? '0 : win[2][i];
    end
  end

  // Axis 0: right column minus left column. Axis 1: bottom row minus top row.
  logic [3*PIX_W-1:0] plusVec  [2];
  logic [3*PIX_W-1:0] minusVec [2];
  logic [SUM_W-1:0]   axisMag  [2];
  logic [SUM_W-1:0]   magReg   [2];

  for (genvar a = 0; a < 2; a++) begin : g_axis
    if (a == 0) begin : g_horiz
      assign plusVec[a]  = {rPix[2], rPix[1], rPix[0]};
      assign minusVec[a] = {lPix[2], lPix[1], lPix[0]};
    end else begin : g_vert
      assign plusVec[a]  = {rPix[2], cPix[2], lPix[2]};
      assign minusVec[a] = {rPix[0], cPix[0], lPix[0]};
    end

    edge_axis_grad #(.PIX_W(PIX_W), .SUM_W(SUM_W)) u_grad (
      .plusPix (plusVec[a]),
      .minusPix(minusVec[a]),
      .mag     (axisMag[a])
    );

    always_ff @(posedge clk) begin
      if (!rstN) magReg[a] <= '0;
      else       magReg[a] <= axisMag[a];
    end
  end

  logic s2Valid;
  always_ff @(posedge clk) begin
    if (!rstN) s2Valid <= 1'b0;
    else       s2Valid <= s1Emit;
  end

  logic [MAG_W-1:0] total;
  logic [PIX_W-1:0] clamped;
  logic             isEdge;

  always_comb begin
    total   = MAG_W'(magReg[0]) + MAG_W'(magReg[1]);
    clamped = (total > MAG_W'({PIX_W{1'b1}})) ? {PIX_W{1'b1}} : total[PIX_W-1:0];
    isEdge  = total > MAG_W'(threshold);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outPix   <= '0;
    end else begin
      outValid <= s2Valid;
      if (s2Valid) begin
        if (mode == MODE_BIN) outPix <= isEdge ? {PIX_W{1'b1}} : '0;
        else                  outPix <= clamped;
      end
    end
  end

endmodule

// File: rtl/prewitt_edge_stream.sv
module prewitt_edge_stream
  import edge_pkg::*;
#(
  parameter int IMG_W = 640,
  parameter int IMG_H = 480,
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sof,
  input  logic             pixValid,
  input  logic [PIX_W-1:0] pixIn,
  input  logic             cfgWe,
  input  logic             cfgSel,
  input  logic [PIX_W-1:0] cfgData,
  output logic             outValid,
  output logic [PIX_W-1:0] outPix
);

  localparam int COL_W = $clog2(IMG_W);

  edgeStrobe_t      strobe;
  logic [COL_W-1:0] lbAddr;
  logic [PIX_W-1:0] threshold;
  outMode_t         mode;

  edge_ctrl #(.IMG_W(IMG_W), .IMG_H(IMG_H), .PIX_W(PIX_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sof      (sof),
    .pixValid (pixValid),
    .cfgWe    (cfgWe),
    .cfgSel   (cfgSel),
    .cfgData  (cfgData),
    .strobe   (strobe),
    .lbAddr   (lbAddr),
    .threshold(threshold),
    .mode     (mode)
  );

  edge_datapath #(.IMG_W(IMG_W), .PIX_W(PIX_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .pixIn    (pixIn),
    .strobe   (strobe),
    .lbAddr   (lbAddr),
    .threshold(threshold),
    .mode     (mode),
    .outValid (outValid),
    .outPix   (outPix)
  );

endmodule

// File: rtl/prewitt_edge_stream_chk.sv
module prewitt_edge_stream_chk #(
  parameter int IMG_W = 640,
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             sof,
  input logic             pixValid,
  input logic             cfgWe,
  input logic             cfgSel,
  input logic             modeBit,
  input logic             outValid,
  input logic [PIX_W-1:0] outPix
);

  logic        modeShadow;
  logic        seenSof;
  logic [31:0] pixSinceSof;
  logic        lateEnough;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeShadow  <= 1'b0;
      seenSof     <= 1'b0;
      pixSinceSof <= '0;
    end else begin
      if (cfgWe && cfgSel) modeShadow <= modeBit;
      if (pixValid && sof) begin
        seenSof     <= 1'b1;
        pixSinceSof <= 32'd1;
      end else if (pixValid && pixSinceSof != 32'hFFFF_FFFF) begin
        pixSinceSof <= pixSinceSof + 32'd1;
      end
    end
  end

  assign lateEnough = pixValid && !sof && seenSof && (pixSinceSof >= 32'(IMG_W + 1));

  // R7: a result needs a pixel accepted three sampling edges earlier
  assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$past(pixValid, 3) |-> !outValid);

  // R2: no result before one line plus one pixel of the frame has arrived
  assert_line_filled_R2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(lateEnough, 3));

  // R4: binary mode only drives the two levels
  assert_binary_levels_R4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(modeShadow)) |-> (outPix == '0 || outPix == {PIX_W{1'b1}}));

  // R9: the pixel that starts a frame never yields a result
  assert_sof_restart_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(pixValid && sof, 3) |-> !outValid);

endmodule

bind prewitt_edge_stream prewitt_edge_stream_chk #(.IMG_W(IMG_W), .PIX_W(PIX_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .sof     (sof),
  .pixValid(pixValid),
  .cfgWe   (cfgWe),
  .cfgSel  (cfgSel),
  .modeBit (cfgData[0]),
  .outValid(outValid),
  .outPix  (outPix)
);

// File: tb/prewitt_edge_stream_bench.sv
`timescale 1ns/1ps
module prewitt_edge_stream_bench;

  localparam int BW = 8;
  localparam int BH = 6;
  localparam int NPIX = BW * BH;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sof = 1'b0;
  logic       pixValid = 1'b0;
  logic [7:0] pixIn = '0;
  logic       cfgWe = 1'b0;
  logic       cfgSel = 1'b0;
  logic [7:0] cfgData = '0;
  logic       outValid;
  logic [7:0] outPix;

  always #10 clk = ~clk;  // 50 MHz

  prewitt_edge_stream #(.IMG_W(BW), .IMG_H(BH), .PIX_W(8)) u_prewitt_edge_stream (
    .clk(clk), .rstN(rstN), .sof(sof), .pixValid(pixValid), .pixIn(pixIn),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .outValid(outValid), .outPix(outPix)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int img [NPIX];
  int gotPix [512];
  int gotCyc [512];
  int gotN = 0;
  int accCyc [512];
  int accN = 0;
  bit finished = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (pixValid && sof) begin
      accCyc[0] <= cyc + 1;
      accN <= 1;
    end else if (pixValid) begin
      if (accN < 512) accCyc[accN] <= cyc + 1;
      accN <= accN + 1;
    end
  end

  always @(negedge clk) begin
    if (outValid) begin
      if (gotN < 512) begin
        gotPix[gotN] = outPix;
        gotCyc[gotN] = cyc;
      end
      gotN = gotN + 1;
    end
  end

  always @(posedge clk) begin
    if (cyc > 60000 && !finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: got cycle %0d expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int pv(input int r, input int c);
    if (r < 0 || r >= BH || c < 0 || c >= BW) return 0;
    return img[r*BW + c];
  endfunction

  function automatic int gradSum(input int r, input int c);
    int gx = 0;
    int gy = 0;
    for (int d = -1; d <= 1; d++) begin
      gx += pv(r + d, c + 1) - pv(r + d, c - 1);
      gy += pv(r + 1, c + d) - pv(r - 1, c + d);
    end
    if (gx < 0) gx = -gx;
    if (gy < 0) gy = -gy;
    return gx + gy;
  endfunction

  function automatic int expOut(input int k, input bit binMode, input int th);
    int s = gradSum(k / BW, k % BW);
    if (binMode) return (s > th) ? 255 : 0;
    return (s > 255) ? 255 : s;
  endfunction

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      pixValid = 1'b0;
      sof = 1'b0;
    end
  endtask

  task automatic pushPix(input bit first, input int val, input int gapPct);
    while (int'($urandom % 100) < gapPct) begin
      @(negedge clk);
      pixValid = 1'b0;
      sof = 1'b0;
    end
    @(negedge clk);
    pixValid = 1'b1;
    sof = first;
    pixIn = val[7:0];
  endtask

  task automatic cfgWrite(input bit sel, input int data);
    @(negedge clk);
    pixValid = 1'b0;
    sof = 1'b0;
    cfgWe = 1'b1;
    cfgSel = sel;
    cfgData = data[7:0];
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // Sends one frame plus drain filler (random non-zero values) plus extra pixels.
  task automatic runFrame(input int gapPct, input int extra, input bit binMode,
                          input int th, input string tag);
    idle(3);
    gotN = 0;
    for (int i = 0; i < NPIX + BW + 1 + extra; i++) begin
      if (i < NPIX) pushPix(i == 0, img[i], gapPct);
      else          pushPix(1'b0, 1 + int'($urandom % 255), gapPct);
    end
    idle(8);
    chk(gotN == NPIX, {tag, " R2 result count"}, gotN, NPIX);
    for (int k = 0; k < NPIX && k < gotN; k++) begin
      chk(gotPix[k] == expOut(k, binMode, th), {tag, " value"}, gotPix[k], expOut(k, binMode, th));
      chk(gotCyc[k] == accCyc[k + BW + 1] + 2, {tag, " R7 latency"}, gotCyc[k], accCyc[k + BW + 1] + 2);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    chk(outValid == 1'b0, "R1 outValid in reset", outValid, 0);
    @(negedge clk);
    rstN = 1'b1;
    chk(outValid == 1'b0, "R1 outValid after reset", outValid, 0);
    chk(outPix == 8'd0, "R1 outPix after reset", outPix, 0);

    // R10: stray pixels with no sof produce nothing
    gotN = 0;
    for (int i = 0; i < 3 * BW; i++) pushPix(1'b0, 200, 0);
    idle(6);
    chk(gotN == 0, "R10 pixels before sof", gotN, 0);

    // R3: random image, gradient mode, back-to-back pixels
    for (int i = 0; i < NPIX; i++) img[i] = int'($urandom % 256);
    cfgWrite(1'b1, 0);
    runFrame(0, 0, 1'b0, 0, "R3");

    // R8 / R4: random image with idle gaps, binary mode, random threshold
    for (int i = 0; i < NPIX; i++) img[i] = int'($urandom % 256);
    begin
      int th = 40 + int'($urandom % 200);
      cfgWrite(1'b0, th);
      cfgWrite(1'b1, 1);
      runFrame(30, 0, 1'b1, th, "R8 R4");
    end

    // R5 / R6: flat full-scale image, borders only, sums above 255 clamp
    for (int i = 0; i < NPIX; i++) img[i] = 255;
    cfgWrite(1'b1, 0);
    runFrame(0, 0, 1'b0, 0, "R5 R6");

    // R11: threshold write with data bit 0 set leaves gradient mode untouched
    for (int i = 0; i < NPIX; i++) img[i] = 1;
    cfgWrite(1'b0, 3);
    runFrame(10, 0, 1'b0, 3, "R11");

    // R4: edge sums equal to the threshold give 0, larger ones give 255
    cfgWrite(1'b1, 1);
    runFrame(0, 0, 1'b1, 3, "R4 strict");

    // R9 / R10: abandoned bright frame, then a fresh frame with extra trailing pixels
    for (int i = 0; i < 20; i++) pushPix(i == 0, 255, 0);
    for (int i = 0; i < NPIX; i++) img[i] = int'($urandom % 256);
    cfgWrite(1'b1, 0);
    runFrame(20, 7, 1'b0, 0, "R9 R10");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule